// File: doc/BRIEF.md
# Memory-Mapped Output Port with Held Interrupt Request

This block is a slave peripheral on a plain 32-bit memory-mapped bus that has a word address, separate read and write strobes, a write data word and a read data word. There are no wait states, and `readdata` is valid in the same cycle as `read`. The block holds an output data word and a direction word. The low `PIN_W` bits of these two words drive the port pins and their output enables. Software can use one of the pins as a timing marker: it sets the pin when it raises the interrupt and clears it when the handler starts. An external instrument can then measure the trigger-to-handler latency.

The block also produces a level interrupt request for a soft processor. Writing a one in bit 0 of the trigger word latches a pending request. The request reaches `irq` only while the enable bit is set. Once raised, the request is never a single-cycle pulse. It holds through idle cycles and through accesses to other words. It falls only on the edge after the service routine makes its acknowledging access to the trigger word. One mutually exclusive case decode on the address picks the register for each access, so exactly one register responds. Software reaches word n at byte offset 4·n.

Top module: `pport_irq_port`

## Requirements
- R1: A synchronous active-high `rst` clears the data, direction and enable registers and the pending flag. After the clock edge that samples `rst`, `irq`, `pin_out` and `pin_oe` are zero.
- R2: Word index 0 is the output data register. A write stores all 32 bits on the next edge, a read returns the stored word, and `pin_out` shows its bits [PIN_W-1:0].
- R3: Word index 1 is the direction register. A write stores all 32 bits, a read returns them, and `pin_oe` shows bits [PIN_W-1:0].
- R4: Word index 5 holds the interrupt enable in bit 0. Only `writedata[0]` is stored. A read returns the enable in bit 0, with bits [31:1] reading as zero.
- R5: A write to word index 7 with `writedata[0]`=1 is a trigger. It sets the pending flag on the next edge, so `irq` is high in the following cycle when the enable is set.
- R6: `irq` is high exactly when the pending flag and the enable bit are both set. A pending request raised while the enable is clear is kept, and it appears on `irq` once the enable is set.
- R7: Once pending, the request stays set through idle cycles and through any access to word indices other than 7.
- R8: A read of word index 7 returns the pending flag in bit 0, with the other bits zero. That read, or a write to index 7 with `writedata[0]`=0, is the acknowledging access. It clears the pending flag on the next edge.
- R9: A trigger write to index 7 while a request is pending counts as both an acknowledging access and a new trigger. The trigger wins and the flag stays set.
- R10: Word indices 2, 3, 4 and 6 read as zero. Writes to them change no register and do not touch the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| address | input | ADDR_W | Word index of the accessed register |
| read | input | 1 | Read strobe for one cycle |
| write | input | 1 | Write strobe for one cycle |
| writedata | input | 32 | Write data word |
| readdata | output | 32 | Read data word, combinational from the address |
| pin_out | output | PIN_W | Port pin values, from the data register |
| pin_oe | output | PIN_W | Port pin output enables, from the direction register |
| irq | output | 1 | Level interrupt request to the processor |

## Verification
Two functions can fall in the same cycle: the acknowledge that clears a pending request, and a new trigger that sets it. A write of one to the trigger word while a request is already pending is both at once. The bench raises a request, issues exactly that write, and then expects `irq` to stay high and a read of the trigger word to return a one. A second case lets a trigger land while the enable is clear. The bench then expects `irq` to stay low, and to rise once the enable is written, with no new trigger.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned IDX_DATA = 0;
  localparam int unsigned IDX_DIR  = 1;
  localparam int unsigned IDX_IEN  = 5;
  localparam int unsigned IDX_TRIG = 7;

  // one-hot register select from the address decode
  typedef struct packed {
    logic data;
    logic dir;
    logic ien;
    logic trig;
    logic none;
  } sel_t;
endpackage

// File: rtl/pport_decode.sv
module pport_decode
  import pport_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] address,
  output sel_t              sel
);
  // single mutually exclusive decode: one branch per access
  always_comb begin
    sel = '0;
    case (address)
      ADDR_W'(IDX_DATA): sel.data = 1'b1;
      ADDR_W'(IDX_DIR):  sel.dir  = 1'b1;
      ADDR_W'(IDX_IEN):  sel.ien  = 1'b1;
      ADDR_W'(IDX_TRIG): sel.trig = 1'b1;
      default:           sel.none = 1'b1;
    endcase
  end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              write,
  input  sel_t              sel,
  input  logic [WORD_W-1:0] writedata,
  output logic [WORD_W-1:0] data_q,
  output logic [WORD_W-1:0] dir_q,
  output logic              ien_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      ien_q  <= 1'b0;
    end else if (write) begin
      if (sel.data) data_q <= writedata;
      if (sel.dir)  dir_q  <= writedata;
      if (sel.ien)  ien_q  <= writedata[0];
    end
  end
endmodule

// File: rtl/pport_irq.sv
module pport_irq
  import pport_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic read,
  input  logic write,
  input  sel_t sel,
  input  logic wd_bit0,
  input  logic ien,
  output logic pending_q,
  output logic irq
);
  logic trig_hit;
  logic ack_hit;

  assign trig_hit = write & sel.trig & wd_bit0;
  assign ack_hit  = (read | write) & sel.trig;

  // held request: set by a trigger, dropped only by the acknowledging access
  always_ff @(posedge clk) begin
    if (rst)           pending_q <= 1'b0;
    else if (trig_hit) pending_q <= 1'b1;
    else if (ack_hit)  pending_q <= 1'b0;
  end

  assign irq = pending_q & ien;
endmodule

// File: rtl/pport_rdmux.sv
module pport_rdmux
  import pport_pkg::*;
(
  input  sel_t              sel,
  input  logic [WORD_W-1:0] data_q,
  input  logic [WORD_W-1:0] dir_q,
  input  logic              ien_q,
  input  logic              pending_q,
  output logic [WORD_W-1:0] readdata
);
  always_comb begin
    readdata = '0;
    unique case (1'b1)
      sel.data: readdata = data_q;
      sel.dir:  readdata = dir_q;
      sel.ien:  readdata = {{(WORD_W-1){1'b0}}, ien_q};
      sel.trig: readdata = {{(WORD_W-1){1'b0}}, pending_q};
      default:  readdata = '0;
    endcase
  end
endmodule

// File: rtl/pport_irq_port.sv
module pport_irq_port
  import pport_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned PIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] address,
  input  logic              read,
  input  logic              write,
  input  logic [31:0]       writedata,
  output logic [31:0]       readdata,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic              irq
);
  sel_t              sel;
  logic [WORD_W-1:0] data_q;
  logic [WORD_W-1:0] dir_q;
  logic              ien_q;
  logic              pending_q;

  pport_decode #(.ADDR_W(ADDR_W)) u_decode (
    .address (address),
    .sel     (sel)
  );

  pport_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .write     (write),
    .sel       (sel),
    .writedata (writedata),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .ien_q     (ien_q)
  );

  pport_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .read      (read),
    .write     (write),
    .sel       (sel),
    .wd_bit0   (writedata[0]),
    .ien       (ien_q),
    .pending_q (pending_q),
    .irq       (irq)
  );

  pport_rdmux u_rdmux (
    .sel       (sel),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .ien_q     (ien_q),
    .pending_q (pending_q),
    .readdata  (readdata)
  );

  assign pin_out = data_q[PIN_W-1:0];
  assign pin_oe  = dir_q[PIN_W-1:0];
endmodule

// File: rtl/pport_irq_port_chk.sv
module pport_irq_port_chk #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned PIN_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] address,
  input logic              read,
  input logic              write,
  input logic [31:0]       writedata,
  input logic [31:0]       readdata,
  input logic [PIN_W-1:0]  pin_out,
  input logic              irq,
  input logic              ien_q
);
  logic at7, at5, at0, mapped;
  assign at7    = (address == ADDR_W'(7));
  assign at5    = (address == ADDR_W'(5));
  assign at0    = (address == ADDR_W'(0));
  assign mapped = at0 || at7 || at5 || (address == ADDR_W'(1));

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!irq && pin_out == '0));

  assert_pin_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (write && at0) |=> (pin_out == $past(writedata[PIN_W-1:0])));

  assert_trigger_raises_R5: assert property (@(posedge clk) disable iff (rst)
    (write && at7 && writedata[0] && ien_q) |=> irq);

  assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !ien_q |-> !irq);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !((read || write) && at7) && !(write && at5)) |=> irq);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    ((read || write) && at7 && !(write && writedata[0])) |=> !irq);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (read && !mapped) |-> (readdata == 32'd0));
endmodule

bind pport_irq_port pport_irq_port_chk #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .address   (address),
  .read      (read),
  .write     (write),
  .writedata (writedata),
  .readdata  (readdata),
  .pin_out   (pin_out),
  .irq       (irq),
  .ien_q     (ien_q)
);

// File: tb/test_pport_irq_port.sv
`timescale 1ns/1ps
module test_pport_irq_port;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PIN_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] address = '0;
  logic              read = 1'b0;
  logic              write = 1'b0;
  logic [31:0]       writedata = '0;
  logic [31:0]       readdata;
  logic [PIN_W-1:0]  pin_out;
  logic [PIN_W-1:0]  pin_oe;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pport_irq_port #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) i_pport_irq_port (
    .clk(clk), .rst(rst), .address(address), .read(read), .write(write),
    .writedata(writedata), .readdata(readdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one-cycle write, applied at a falling edge
  task automatic bus_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    address = ADDR_W'(idx); writedata = d; write = 1'b1;
    @(negedge clk);
    write = 1'b0; writedata = '0;
  endtask

  // driver: one-cycle read, expected word goes to the scoreboard
  task automatic bus_read(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    address = ADDR_W'(idx); read = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    read = 1'b0;
  endtask

  // sample the outputs settled, after the last edge's updates
  task automatic idle_check_irq(input logic exp, input string tag);
    @(negedge clk); #2;
    check({31'd0, irq}, {31'd0, exp}, tag);
  endtask

  // monitor: pops the expected word for each read cycle
  initial begin
    forever begin
      @(negedge clk); #2;
      if (read) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard empty actual=%h expected=none", readdata);
        end else begin
          check(readdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check({31'd0, irq}, 32'd0, "R1 irq after reset");
    check({16'd0, pin_out}, 32'd0, "R1 pin_out after reset");
    check({16'd0, pin_oe}, 32'd0, "R1 pin_oe after reset");
    bus_read(0, 32'd0, "R1 data reg reset");
    bus_read(7, 32'd0, "R1 pending reset");

    bus_write(0, 32'hA5A5_1234);
    bus_read(0, 32'hA5A5_1234, "R2 data readback");
    check({16'd0, pin_out}, 32'h0000_1234, "R2 pin_out");
    bus_write(1, 32'h0000_FF0F);
    bus_read(1, 32'h0000_FF0F, "R3 dir readback");
    check({16'd0, pin_oe}, 32'h0000_FF0F, "R3 pin_oe");
    bus_write(5, 32'hFFFF_FFFF);
    bus_read(5, 32'd1, "R4 enable readback");

    // trigger and hold
    bus_write(7, 32'd1);
    #2 check({31'd0, irq}, 32'd1, "R5 irq after trigger");
    for (int i = 0; i < 5; i++) idle_check_irq(1'b1, "R7 irq held idle");
    bus_write(0, 32'h0000_00FF);
    bus_read(1, 32'h0000_FF0F, "R7 other read");
    #2 check({31'd0, irq}, 32'd1, "R7 irq held after other accesses");
    bus_read(7, 32'd1, "R8 pending readback");
    #2 check({31'd0, irq}, 32'd0, "R8 irq cleared by read ack");
    bus_read(7, 32'd0, "R8 pending cleared");

    // gated trigger is kept
    bus_write(5, 32'd0);
    bus_write(7, 32'd1);
    #2 check({31'd0, irq}, 32'd0, "R6 irq gated by enable");
    bus_write(5, 32'd1);
    #2 check({31'd0, irq}, 32'd1, "R6 held request shows on enable");
    bus_write(7, 32'd0);
    #2 check({31'd0, irq}, 32'd0, "R8 irq cleared by write ack");

    // trigger collides with acknowledge
    bus_write(7, 32'd1);
    bus_write(7, 32'd1);
    #2 check({31'd0, irq}, 32'd1, "R9 trigger wins over ack");
    bus_read(7, 32'd1, "R9 pending still set");
    #2 check({31'd0, irq}, 32'd0, "R9 cleared afterwards");

    // unmapped words
    bus_write(3, 32'hFFFF_FFFF);
    bus_write(6, 32'hFFFF_FFFF);
    bus_write(2, 32'd1);
    bus_read(3, 32'd0, "R10 index 3 reads zero");
    bus_read(6, 32'd0, "R10 index 6 reads zero");
    bus_read(0, 32'h0000_00FF, "R10 data unchanged");
    bus_read(1, 32'h0000_FF0F, "R10 dir unchanged");
    bus_read(5, 32'd1, "R10 enable unchanged");
    #2 check({31'd0, irq}, 32'd0, "R10 no trigger from unmapped");

    // reset while pending
    bus_write(7, 32'd1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #2;
    check({31'd0, irq}, 32'd0, "R1 reset drops irq");
    check({16'd0, pin_out}, 32'd0, "R1 reset clears pins");
    bus_read(5, 32'd0, "R1 enable cleared");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule